// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a 12-bit successive-approximation conversion. A host starts it by pulling chip-select and read low together while the byte-select input is low. The controller then drives a trial code to an external DAC, reads back a one-bit comparator decision each cycle, and builds the converted word one bit at a time from the most significant bit down. An active-low busy flag covers the whole conversion. When the last bit is decided, the finished word is moved into a result latch that the host reads.

Every conversion takes a fixed frame of thirteen clock cycles. The first cycle lets the DAC settle on the MSB trial. Each of the next twelve cycles decides one bit. A start request seen while a frame is running has no effect. A request is taken only on its asserting edge, so a request held low past the end of a frame does not start a second conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_n is 1, result is 0 and dac_code is 0. No conversion runs until a start edge arrives.
- R2: A start request exists only while cs_n = 0, rd_n = 0 and hben = 0. With hben = 1, holding cs_n and rd_n low never drives busy_n low, and result is left unchanged.
- R3: Starting a conversion clears the approximation word. In the first busy cycle dac_code is exactly 0x800, whatever the previous result was.
- R4: busy_n stays low for exactly 13 consecutive clock cycles per conversion.
- R5: Bits are tried from bit 11 down to bit 0. In busy cycle c (counted from 0), the trial bit is 11 when c = 0 and 12 − c otherwise. dac_code equals the bits above the trial bit that were already decided, with the trial bit set and all lower bits clear. The MSB is therefore decided on the second rising edge after the start.
- R6: comp_in = 1 keeps the trial bit and comp_in = 0 drops it. With an ideal comparator (comp_in = 1 when dac_code ≤ input), the final result equals the input code.
- R7: busy_n returns high on the same clock edge on which result takes the new word.
- R8: result keeps the previous conversion's value during every cycle of a running conversion.
- R9: A start request edge that arrives while a conversion is running is ignored. The frame neither restarts nor lengthens, and no second conversion follows it.
- R10: A start request held asserted across the end of a conversion does not trigger another conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | Byte select; high suppresses a start |
| comp_in | input | 1 | Comparator decision, 1 = keep trial bit |
| dac_code | output | 12 | Trial code presented to the DAC |
| busy_n | output | 1 | Low while a conversion runs |
| result | output | 12 | Latched word of the last completed conversion |

## Verification
Two events can land on the same edge. One is the end of a frame, when busy_n rises and result loads. The other is the detection of a fresh start request. The bench provokes this in two ways. It releases and re-asserts chip-select and read in the middle of a frame, so the request edge arrives while busy. It also holds the request low through the end of a frame. In both cases it judges that the frame stays exactly thirteen cycles, that the result is the input code, and that busy_n then stays high. A full sweep of every input code checks each trial code cycle by cycle against a model built from the bit order.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } conv_state_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic hben,
   output logic start
);
   logic req_raw;
   logic req_s;
   logic req_d;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..4");
   end

   // request formed before synchronisation so all three inputs are seen together
   assign req_raw = !cs_n && !rd_n && !hben;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign req_s = req_raw;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= 1'b0;
         else        sh <= req_raw;
      end
      assign req_s = sh;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2:0], req_raw};
      end
      assign req_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req_s;
   end

   assign start = req_s && !req_d;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_pkg::*;
#(
   parameter int WIDTH  = 12,
   parameter int SETTLE = 1,
   localparam int FRAME = SETTLE + WIDTH,
   localparam int PW    = $clog2(FRAME),
   localparam int IW    = $clog2(WIDTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          load,
   output logic          decide,
   output logic          done,
   output logic [IW-1:0] bit_idx
);
   localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

   conv_state_e   state;
   logic [PW-1:0] phase;
   int            idx_i;

   if (WIDTH < 2) begin : g_bad_width
      $error("WIDTH must be at least 2");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end

   assign busy   = (state == ST_CONV);
   assign load   = start && !busy;
   assign decide = busy && (int'(phase) >= SETTLE);
   assign done   = busy && (phase == LAST);

   always_comb begin
      if (int'(phase) < SETTLE) idx_i = WIDTH - 1;
      else                      idx_i = WIDTH - 1 - (int'(phase) - SETTLE);
      bit_idx = IW'(idx_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         phase <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_CONV;
                  phase <= '0;
               end
            end
            default: begin
               if (phase == LAST) state <= ST_IDLE;
               else               phase <= phase + PW'(1);
            end
         endcase
      end
   end

   // R9: a start edge inside a running frame never sends the frame back to phase 0
   assert_ignore_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && phase != LAST) |=> (phase != '0));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
   parameter int WIDTH = 12,
   localparam int IW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             decide,
   input  logic             done,
   input  logic             busy,
   input  logic [IW-1:0]    bit_idx,
   input  logic             comp_in,
   output logic [WIDTH-1:0] dac_code,
   output logic [WIDTH-1:0] result
);
   logic [WIDTH-1:0] sar;
   logic [WIDTH-1:0] mask;
   logic [WIDTH-1:0] kept;

   assign mask     = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;
   assign kept     = comp_in ? (sar | mask) : sar;
   assign dac_code = busy ? (sar | mask) : sar;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sar    <= '0;
         result <= '0;
      end else begin
         if (load)        sar <= '0;
         else if (decide) sar <= kept;
         if (done)        result <= kept;
      end
   end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int WIDTH       = 12,
   parameter int SETTLE      = 1,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME = SETTLE + WIDTH,
   localparam int IW    = $clog2(WIDTH),
   localparam int CW    = $clog2(FRAME + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             hben,
   input  logic             comp_in,
   output logic [WIDTH-1:0] dac_code,
   output logic             busy_n,
   output logic [WIDTH-1:0] result
);
   localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

   logic          start;
   logic          busy;
   logic          load;
   logic          decide;
   logic          done;
   logic [IW-1:0] bit_idx;

   sar_start_detect #(.SYNC_STAGES(SYNC_STAGES)) u_start (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
      .start(start)
   );

   sar_sequencer #(.WIDTH(WIDTH), .SETTLE(SETTLE)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .load(load),
      .decide(decide), .done(done), .bit_idx(bit_idx)
   );

   sar_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .decide(decide), .done(done),
      .busy(busy), .bit_idx(bit_idx), .comp_in(comp_in),
      .dac_code(dac_code), .result(result)
   );

   assign busy_n = !busy;

   // frame-length window counted here, not by a long $past
   logic [CW-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_cnt <= '0;
      else if (busy_n) low_cnt <= '0;
      else             low_cnt <= low_cnt + CW'(1);
   end

   assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> (low_cnt == CW'(FRAME)));

   assert_sar_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> (dac_code == MSB_MASK));

   assert_done_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> (result == dac_code));

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |=> (busy_n || $stable(result)));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_n, rd_n, hben;
   logic        comp_in;
   logic [11:0] dac_code;
   logic        busy_n;
   logic [11:0] result;
   logic [11:0] vin;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   // ideal DAC + comparator: keep when trial does not exceed the input
   assign comp_in = (dac_code <= vin);

   sar_conv_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
      .comp_in(comp_in), .dac_code(dac_code), .busy_n(busy_n), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         finish_run();
      end
   end

   function automatic logic [11:0] exp_trial(input int c, input logic [11:0] v);
      int idx;
      logic [11:0] upper;
      idx   = (c == 0) ? 11 : 12 - c;
      upper = v & ~((12'h1 << (idx + 1)) - 12'h1);
      if (idx == 11) upper = 12'h0;
      return upper | (12'h1 << idx);
   endfunction

   // mode 0 plain, 1 re-request mid frame, 2 hold request past end
   task automatic run_conv(input logic [11:0] v, input int mode);
      logic [11:0] old;
      int c;
      int wait_n;
      vin = v;
      @(negedge clk);
      old  = result;
      cs_n = 1'b0; rd_n = 1'b0;
      wait_n = 0;
      while (busy_n && wait_n < 8) begin
         @(negedge clk);
         wait_n++;
      end
      chk(wait_n <= 3, "R2 start seen", wait_n, 3);
      c = 0;
      while (!busy_n && c < 20) begin
         if (c < 13) begin
            chk(dac_code == exp_trial(c, v), (c == 0) ? "R3 cleared trial" : "R5 trial order",
                dac_code, exp_trial(c, v));
            chk(result == old, "R8 result held", result, old);
         end
         if (c == 2 && mode != 2) begin cs_n = 1'b1; rd_n = 1'b1; end
         if (c == 5 && mode == 1) begin cs_n = 1'b0; rd_n = 1'b0; end
         if (c == 8 && mode == 1) begin cs_n = 1'b1; rd_n = 1'b1; end
         @(negedge clk);
         c++;
      end
      chk(c == 13, "R4 busy length", c, 13);
      chk(result == v, "R6 final code", result, v);
      chk(busy_n == 1'b1 && result == v, "R7 busy and latch together", result, v);
      if (mode == 2) begin
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(busy_n == 1'b1, "R10 held request no retrigger", busy_n, 1);
         end
         cs_n = 1'b1; rd_n = 1'b1;
      end
      if (mode == 1) begin
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(busy_n == 1'b1, "R9 mid-frame request ignored", busy_n, 1);
         end
         chk(result == v, "R9 result intact", result, v);
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0; vin = 12'h0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_n == 1'b1, "R1 reset busy_n", busy_n, 1);
      chk(result == 12'h0, "R1 reset result", result, 0);
      chk(dac_code == 12'h0, "R1 reset dac_code", dac_code, 0);
      repeat (4) @(negedge clk);
      chk(busy_n == 1'b1, "R1 idle without start", busy_n, 1);

      run_conv(12'hA5C, 0);

      // byte select high: request must not start anything
      hben = 1'b1;
      cs_n = 1'b0; rd_n = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(busy_n == 1'b1, "R2 hben suppresses start", busy_n, 1);
      end
      chk(result == 12'hA5C, "R2 result untouched", result, 12'hA5C);
      cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      hben = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy_n == 1'b1, "R2 no late start", busy_n, 1);

      run_conv(12'hFFF, 0);
      run_conv(12'h000, 0);
      run_conv(12'h800, 0);
      run_conv(12'h7FF, 1);
      run_conv(12'h3C3, 1);
      run_conv(12'h001, 2);
      run_conv(12'hFFE, 2);

      for (int v = 0; v < 4096; v++) run_conv(12'(v), 0);

      finish_run();
   end
endmodule